// File: doc/BRIEF.md
# Variable-Length Instruction Predecoder

This block sits between an instruction word queue and a decode stage. It receives 16-bit instruction words one at a time over a valid/ready handshake. From the first word of each instruction it works out the instruction layout: one of three formats, the register numbers, and the source and destination addressing modes. The addressing mode depends on both the register number and the mode bits. A few registers turn into a symbolic, immediate or absolute operand, or into a built-in constant. The mode decides how many extension words follow, so the block counts that number of words off the stream and attaches them to the instruction.

After the last word of an instruction is taken, the block offers one decoded bundle. The bundle holds the opcode word, the format, the registers and modes, the constant value, the extension words and the total length. An illegal source encoding sets a flag in the bundle and uses up only the word that carried it. A downstream decoder or a trace unit reads the bundle and handshakes it away before the next instruction starts.

Top module: `instr_predecoder`

## Requirements
- R1: Bits 15:13 of the first word select the format, reported on `fmt_o`: 000 gives 0 (single-operand), 001 gives 1 (relative jump), and any other value gives 2 (two-operand).
- R2: In two-operand format the source register comes from bits 11:8, the source mode from bits 5:4, the destination register from bits 3:0 and the destination mode from bit 7. In single-operand format the only operand is reported as the source, with its register from bits 3:0 and its mode from bits 5:4. The destination is then reported as register 0, mode code 0.
- R3: Mode codes are: 0 register, 1 indexed, 2 indirect, 3 indirect post-increment, 4 symbolic, 5 immediate, 6 absolute, 7 constant, 8 illegal. Source register 0 gives symbolic for mode bits 1, illegal for 2, immediate for 3 and register for 0.
- R4: Source register 2 gives register for mode bits 0, absolute for 1, and constant for 2 or 3. Source register 3 is always constant. The constant values are 4 (reg 2, bits 2), 8 (reg 2, bits 3), and 0, 1, 2 and 16'hFFFF (reg 3, bits 0 to 3). `const_valid_o` is 1 exactly when the source mode is constant, and `const_o` is 0 otherwise.
- R5: Every other source register maps mode bits 0, 1, 2 and 3 to register, indexed, indirect and indirect post-increment.
- R6: A destination mode bit of 0 gives register mode. A bit of 1 gives symbolic for register 0, absolute for register 2 and indexed for any other register.
- R7: An indexed, symbolic, immediate or absolute source adds one extension word, and an indexed, symbolic or absolute destination adds one more. `len_o` is 1 to 3. The first word following the opcode lands in `ext0_o` and the second in `ext1_o`. An unused extension output reads 0.
- R8: An illegal source mode sets `illegal_o`, gives `len_o` = 1, and consumes only the opcode word. The next word is then decoded as a new opcode word.
- R9: A relative jump is always one word long, with both registers 0 and both mode codes 0, whatever its low bits hold.
- R10: While `out_valid_o` is high and `out_ready_i` is low, every bundle output stays unchanged and `in_ready_o` is 0, so no input word is taken.
- R11: A synchronous reset (`rst_i` high at a clock edge) drops any partly collected instruction. After it, `out_valid_o` is 0, `in_ready_o` is 1, and the next word taken is treated as an opcode word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| in_valid_i | input | 1 | An input word is offered |
| in_word_i | input | 16 | Instruction word |
| in_ready_o | output | 1 | The block takes the offered word at this edge |
| out_valid_o | output | 1 | A decoded bundle is offered |
| out_ready_i | input | 1 | The consumer takes the bundle at this edge |
| opword_o | output | 16 | First word of the instruction |
| fmt_o | output | 2 | Format code (R1) |
| src_reg_o | output | 4 | Source register number |
| src_mode_o | output | 4 | Source mode code (R3) |
| dst_reg_o | output | 4 | Destination register number |
| dst_mode_o | output | 4 | Destination mode code |
| const_o | output | 16 | Constant generator value |
| const_valid_o | output | 1 | Source is a generated constant |
| ext0_o | output | 16 | First extension word |
| ext1_o | output | 16 | Second extension word |
| len_o | output | 2 | Instruction length in words |
| illegal_o | output | 1 | Illegal source encoding |

## Verification
The hardest case to reach is a reset that arrives in the middle of an instruction. By then the opcode word and part of its extensions have been taken and no bundle has appeared. A wrong design would go on to treat the next word as an extension. The bench sends a three-word instruction, stops after its first extension word, pulses reset, and then sends a one-word instruction. That instruction must come out alone, with zero extensions. A second hard case is a stalled bundle while the input side keeps offering a word. The bench holds the word on the input across several stalled cycles and checks that it is taken exactly once, only after the bundle has been accepted.

// File: rtl/predec_pkg.sv
package predec_pkg;
    localparam int WORD_W  = 16;
    localparam int REG_W   = 4;
    localparam int MAX_EXT = 2;
    localparam int IDX_W   = (MAX_EXT > 1) ? $clog2(MAX_EXT) : 1;
    localparam int LEN_W   = $clog2(MAX_EXT + 2);

    // first-word field positions
    localparam int FMT_LSB  = 13;
    localparam int SREG_LSB = 8;
    localparam int AD_BIT   = 7;
    localparam int AS_LSB   = 4;
    localparam int DREG_LSB = 0;

    typedef enum logic [1:0] {
        FMT_SINGLE = 2'd0,
        FMT_JUMP   = 2'd1,
        FMT_DUAL   = 2'd2
    } fmt_e;

    typedef enum logic [3:0] {
        AM_REG   = 4'd0,
        AM_IDX   = 4'd1,
        AM_IND   = 4'd2,
        AM_INDPI = 4'd3,
        AM_SYM   = 4'd4,
        AM_IMM   = 4'd5,
        AM_ABS   = 4'd6,
        AM_CONST = 4'd7,
        AM_BAD   = 4'd8
    } amode_e;

    typedef enum logic [1:0] {
        PH_FIRST = 2'd0,
        PH_EXT   = 2'd1,
        PH_OUT   = 2'd2
    } phase_e;
endpackage

// File: rtl/predec_srcmode.sv
module predec_srcmode
    import predec_pkg::*;
(
    input  logic [REG_W-1:0]  reg_i,
    input  logic [1:0]        bits_i,
    output amode_e            mode_o,
    output logic [WORD_W-1:0] cval_o,
    output logic              cvld_o,
    output logic              ext_o
);
    always_comb begin
        mode_o = AM_REG;
        cval_o = '0;
        case (reg_i)
            REG_W'(0): begin
                case (bits_i)
                    2'd1:    mode_o = AM_SYM;
                    2'd2:    mode_o = AM_BAD;
                    2'd3:    mode_o = AM_IMM;
                    default: mode_o = AM_REG;
                endcase
            end
            REG_W'(2): begin
                case (bits_i)
                    2'd1: mode_o = AM_ABS;
                    2'd2: begin mode_o = AM_CONST; cval_o = WORD_W'(4); end
                    2'd3: begin mode_o = AM_CONST; cval_o = WORD_W'(8); end
                    default: mode_o = AM_REG;
                endcase
            end
            REG_W'(3): begin
                mode_o = AM_CONST;
                // 0, 1, 2 and all ones
                cval_o = (bits_i == 2'd3) ? '1 : WORD_W'(bits_i);
            end
            default: mode_o = amode_e'({2'b00, bits_i});
        endcase
        cvld_o = (mode_o == AM_CONST);
        ext_o  = (mode_o == AM_IDX) || (mode_o == AM_SYM) ||
                 (mode_o == AM_IMM) || (mode_o == AM_ABS);
    end
endmodule

// File: rtl/predec_dstmode.sv
module predec_dstmode
    import predec_pkg::*;
(
    input  logic [REG_W-1:0] reg_i,
    input  logic             bit_i,
    output amode_e           mode_o,
    output logic             ext_o
);
    always_comb begin
        if (!bit_i)                  mode_o = AM_REG;
        else if (reg_i == REG_W'(0)) mode_o = AM_SYM;
        else if (reg_i == REG_W'(2)) mode_o = AM_ABS;
        else                         mode_o = AM_IDX;
        ext_o = bit_i;
    end
endmodule

// File: rtl/predec_classify.sv
module predec_classify
    import predec_pkg::*;
(
    input  logic [WORD_W-1:0] word_i,
    output fmt_e              fmt_o,
    output logic [REG_W-1:0]  sreg_o,
    output amode_e            smode_o,
    output logic [REG_W-1:0]  dreg_o,
    output amode_e            dmode_o,
    output logic [WORD_W-1:0] cval_o,
    output logic              cvld_o,
    output logic [1:0]        next_o,
    output logic              bad_o
);
    logic [2:0]        top_bits;
    logic [REG_W-1:0]  s_reg;
    logic [REG_W-1:0]  d_reg;
    amode_e            s_mode;
    amode_e            d_mode;
    logic [WORD_W-1:0] s_cval;
    logic              s_cvld;
    logic              s_ext;
    logic              d_ext;

    assign top_bits = word_i[FMT_LSB +: 3];
    assign d_reg    = word_i[DREG_LSB +: REG_W];
    // single-operand keeps its register where two-operand keeps the destination
    assign s_reg    = (top_bits == 3'd0) ? word_i[DREG_LSB +: REG_W]
                                         : word_i[SREG_LSB +: REG_W];

    predec_srcmode u_src (
        .reg_i  (s_reg),
        .bits_i (word_i[AS_LSB +: 2]),
        .mode_o (s_mode),
        .cval_o (s_cval),
        .cvld_o (s_cvld),
        .ext_o  (s_ext)
    );

    predec_dstmode u_dst (
        .reg_i  (d_reg),
        .bit_i  (word_i[AD_BIT]),
        .mode_o (d_mode),
        .ext_o  (d_ext)
    );

    always_comb begin
        sreg_o  = s_reg;
        smode_o = s_mode;
        cval_o  = s_cval;
        cvld_o  = s_cvld;
        dreg_o  = '0;
        dmode_o = AM_REG;
        bad_o   = (s_mode == AM_BAD);
        next_o  = {1'b0, s_ext};
        case (top_bits)
            3'd0: fmt_o = FMT_SINGLE;
            3'd1: begin
                fmt_o   = FMT_JUMP;
                sreg_o  = '0;
                smode_o = AM_REG;
                cval_o  = '0;
                cvld_o  = 1'b0;
                bad_o   = 1'b0;
                next_o  = 2'd0;
            end
            default: begin
                fmt_o   = FMT_DUAL;
                dreg_o  = d_reg;
                dmode_o = d_mode;
                next_o  = {1'b0, s_ext} + {1'b0, d_ext};
            end
        endcase
        if (bad_o) next_o = 2'd0;
    end
endmodule

// File: rtl/instr_predecoder.sv
module instr_predecoder
    import predec_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              in_valid_i,
    input  logic [15:0]       in_word_i,
    output logic              in_ready_o,
    output logic              out_valid_o,
    input  logic              out_ready_i,
    output logic [15:0]       opword_o,
    output logic [1:0]        fmt_o,
    output logic [3:0]        src_reg_o,
    output logic [3:0]        src_mode_o,
    output logic [3:0]        dst_reg_o,
    output logic [3:0]        dst_mode_o,
    output logic [15:0]       const_o,
    output logic              const_valid_o,
    output logic [15:0]       ext0_o,
    output logic [15:0]       ext1_o,
    output logic [1:0]        len_o,
    output logic              illegal_o
);
    typedef struct packed {
        phase_e                          phase;
        logic [WORD_W-1:0]               opword;
        fmt_e                            fmt;
        logic [REG_W-1:0]                sreg;
        amode_e                          smode;
        logic [REG_W-1:0]                dreg;
        amode_e                          dmode;
        logic [WORD_W-1:0]               cval;
        logic                            cvld;
        logic                            bad;
        logic [LEN_W-1:0]                len;
        logic [1:0]                      left;
        logic [IDX_W-1:0]                idx;
        logic [MAX_EXT-1:0][WORD_W-1:0]  ext;
    } state_t;

    state_t st_d, st_q;

    fmt_e              c_fmt;
    logic [REG_W-1:0]  c_sreg, c_dreg;
    amode_e            c_smode, c_dmode;
    logic [WORD_W-1:0] c_cval;
    logic              c_cvld, c_bad;
    logic [1:0]        c_next;

    predec_classify u_cls (
        .word_i  (in_word_i),
        .fmt_o   (c_fmt),
        .sreg_o  (c_sreg),
        .smode_o (c_smode),
        .dreg_o  (c_dreg),
        .dmode_o (c_dmode),
        .cval_o  (c_cval),
        .cvld_o  (c_cvld),
        .next_o  (c_next),
        .bad_o   (c_bad)
    );

    always_comb begin
        st_d = st_q;
        case (st_q.phase)
            PH_FIRST: begin
                if (in_valid_i) begin
                    st_d.opword = in_word_i;
                    st_d.fmt    = c_fmt;
                    st_d.sreg   = c_sreg;
                    st_d.smode  = c_smode;
                    st_d.dreg   = c_dreg;
                    st_d.dmode  = c_dmode;
                    st_d.cval   = c_cval;
                    st_d.cvld   = c_cvld;
                    st_d.bad    = c_bad;
                    st_d.ext    = '0;
                    st_d.idx    = '0;
                    st_d.left   = c_next;
                    st_d.len    = LEN_W'(c_next) + LEN_W'(1);
                    st_d.phase  = (c_next == 2'd0) ? PH_OUT : PH_EXT;
                end
            end
            PH_EXT: begin
                if (in_valid_i) begin
                    st_d.ext[st_q.idx] = in_word_i;
                    st_d.idx           = st_q.idx + IDX_W'(1);
                    st_d.left          = st_q.left - 2'd1;
                    if (st_q.left == 2'd1) st_d.phase = PH_OUT;
                end
            end
            PH_OUT: begin
                if (out_ready_i) st_d.phase = PH_FIRST;
            end
            default: st_d.phase = PH_FIRST;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) st_q <= '0;
        else       st_q <= st_d;
    end

    assign in_ready_o    = (st_q.phase == PH_FIRST) || (st_q.phase == PH_EXT);
    assign out_valid_o   = (st_q.phase == PH_OUT);
    assign opword_o      = st_q.opword;
    assign fmt_o         = st_q.fmt;
    assign src_reg_o     = st_q.sreg;
    assign src_mode_o    = st_q.smode;
    assign dst_reg_o     = st_q.dreg;
    assign dst_mode_o    = st_q.dmode;
    assign const_o       = st_q.cval;
    assign const_valid_o = st_q.cvld;
    assign ext0_o        = st_q.ext[0];
    assign ext1_o        = st_q.ext[1];
    assign len_o         = st_q.len;
    assign illegal_o     = st_q.bad;

    // R10: a stalled bundle does not move
    p_stall_hold_r10: assert property (@(posedge clk_i) disable iff (rst_i)
        (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(opword_o) &&
            $stable(len_o) && $stable(ext0_o) && $stable(ext1_o) &&
            $stable(src_mode_o) && $stable(dst_mode_o) && $stable(illegal_o)));

    // R10: the input side is closed while a bundle is offered
    p_no_take_r10: assert property (@(posedge clk_i) disable iff (rst_i)
        out_valid_o |-> !in_ready_o);

    // R7: length stays within one to three words
    p_len_range_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        out_valid_o |-> (len_o >= 2'd1 && len_o <= 2'd3));

    // R7: a one-word bundle carries no extension data
    p_ext_clear_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        (out_valid_o && len_o == 2'd1) |-> (ext0_o == '0 && ext1_o == '0));

    // R8: an illegal encoding is one word long
    p_bad_len_r8: assert property (@(posedge clk_i) disable iff (rst_i)
        (out_valid_o && illegal_o) |-> (len_o == 2'd1));

    // R9: jumps are single words
    p_jump_len_r9: assert property (@(posedge clk_i) disable iff (rst_i)
        (out_valid_o && fmt_o == 2'd1) |-> (len_o == 2'd1 && !illegal_o));

    // R4: the constant flag tracks the constant mode
    p_const_flag_r4: assert property (@(posedge clk_i) disable iff (rst_i)
        out_valid_o |-> (const_valid_o == (src_mode_o == 4'd7)));
endmodule

// File: tb/instr_predecoder_tb.sv
module instr_predecoder_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [15:0] in_word;
    logic        in_ready;
    logic        out_valid;
    logic        out_ready;
    logic [15:0] opword;
    logic [1:0]  fmt;
    logic [3:0]  src_reg, src_mode, dst_reg, dst_mode;
    logic [15:0] cval;
    logic        cvld;
    logic [15:0] ext0, ext1;
    logic [1:0]  len;
    logic        illegal;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    instr_predecoder u_dut (
        .clk_i(clk), .rst_i(rst), .in_valid_i(in_valid), .in_word_i(in_word),
        .in_ready_o(in_ready), .out_valid_o(out_valid), .out_ready_i(out_ready),
        .opword_o(opword), .fmt_o(fmt), .src_reg_o(src_reg), .src_mode_o(src_mode),
        .dst_reg_o(dst_reg), .dst_mode_o(dst_mode), .const_o(cval),
        .const_valid_o(cvld), .ext0_o(ext0), .ext1_o(ext1), .len_o(len),
        .illegal_o(illegal)
    );

    typedef struct packed {
        logic [1:0]  n;
        logic [15:0] w0, w1, w2;
        logic [1:0]  fmt;
        logic [3:0]  sreg, smode, dreg, dmode;
        logic [15:0] cval;
        logic        cvld;
        logic        bad;
    } vec_t;

    localparam int NV = 23;
    localparam vec_t VECS [NV] = '{
        '{2'd1, 16'h4504, 16'h0000, 16'h0000, 2'd2, 4'h5, 4'd0, 4'h4, 4'd0, 16'h0000, 1'b0, 1'b0},
        '{2'd3, 16'h4697, 16'h1111, 16'h2222, 2'd2, 4'h6, 4'd1, 4'h7, 4'd1, 16'h0000, 1'b0, 1'b0},
        '{2'd2, 16'h5039, 16'hABCD, 16'h0000, 2'd2, 4'h0, 4'd5, 4'h9, 4'd0, 16'h0000, 1'b0, 1'b0},
        '{2'd3, 16'h6092, 16'h0102, 16'h0304, 2'd2, 4'h0, 4'd4, 4'h2, 4'd6, 16'h0000, 1'b0, 1'b0},
        '{2'd1, 16'h4225, 16'h0000, 16'h0000, 2'd2, 4'h2, 4'd7, 4'h5, 4'd0, 16'h0004, 1'b1, 1'b0},
        '{2'd2, 16'h82B0, 16'h5555, 16'h0000, 2'd2, 4'h2, 4'd7, 4'h0, 4'd4, 16'h0008, 1'b1, 1'b0},
        '{2'd1, 16'h430A, 16'h0000, 16'h0000, 2'd2, 4'h3, 4'd7, 4'hA, 4'd0, 16'h0000, 1'b1, 1'b0},
        '{2'd1, 16'h431B, 16'h0000, 16'h0000, 2'd2, 4'h3, 4'd7, 4'hB, 4'd0, 16'h0001, 1'b1, 1'b0},
        '{2'd1, 16'h432C, 16'h0000, 16'h0000, 2'd2, 4'h3, 4'd7, 4'hC, 4'd0, 16'h0002, 1'b1, 1'b0},
        '{2'd1, 16'h433D, 16'h0000, 16'h0000, 2'd2, 4'h3, 4'd7, 4'hD, 4'd0, 16'hFFFF, 1'b1, 1'b0},
        '{2'd2, 16'h421E, 16'h0200, 16'h0000, 2'd2, 4'h2, 4'd6, 4'hE, 4'd0, 16'h0000, 1'b0, 1'b0},
        '{2'd1, 16'h4824, 16'h0000, 16'h0000, 2'd2, 4'h8, 4'd2, 4'h4, 4'd0, 16'h0000, 1'b0, 1'b0},
        '{2'd1, 16'h4931, 16'h0000, 16'h0000, 2'd2, 4'h9, 4'd3, 4'h1, 4'd0, 16'h0000, 1'b0, 1'b0},
        '{2'd1, 16'h40A5, 16'h0000, 16'h0000, 2'd2, 4'h0, 4'd8, 4'h5, 4'd1, 16'h0000, 1'b0, 1'b1},
        '{2'd1, 16'h4C0D, 16'h0000, 16'h0000, 2'd2, 4'hC, 4'd0, 4'hD, 4'd0, 16'h0000, 1'b0, 1'b0},
        '{2'd2, 16'h1094, 16'h7777, 16'h0000, 2'd0, 4'h4, 4'd1, 4'h0, 4'd0, 16'h0000, 1'b0, 1'b0},
        '{2'd1, 16'h1020, 16'h0000, 16'h0000, 2'd0, 4'h0, 4'd8, 4'h0, 4'd0, 16'h0000, 1'b0, 1'b1},
        '{2'd2, 16'h1030, 16'h8888, 16'h0000, 2'd0, 4'h0, 4'd5, 4'h0, 4'd0, 16'h0000, 1'b0, 1'b0},
        '{2'd1, 16'h1233, 16'h0000, 16'h0000, 2'd0, 4'h3, 4'd7, 4'h0, 4'd0, 16'hFFFF, 1'b1, 1'b0},
        '{2'd1, 16'h3C05, 16'h0000, 16'h0000, 2'd1, 4'h0, 4'd0, 4'h0, 4'd0, 16'h0000, 1'b0, 1'b0},
        '{2'd1, 16'h2030, 16'h0000, 16'h0000, 2'd1, 4'h0, 4'd0, 4'h0, 4'd0, 16'h0000, 1'b0, 1'b0},
        '{2'd3, 16'hF0B2, 16'h1234, 16'h5678, 2'd2, 4'h0, 4'd5, 4'h2, 4'd6, 16'h0000, 1'b0, 1'b0},
        '{2'd1, 16'h4802, 16'h0000, 16'h0000, 2'd2, 4'h8, 4'd0, 4'h2, 4'd0, 16'h0000, 1'b0, 1'b0}
    };

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic send(input logic [15:0] w);
        @(negedge clk);
        in_valid = 1'b1;
        in_word  = w;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic wait_bundle(input string tag);
        int n = 0;
        while (!out_valid && n < 50) begin
            @(negedge clk);
            n++;
        end
        if (!out_valid) chk({tag, " bundle timeout"}, 16'd0, 16'd1);
    endtask

    task automatic take;
        @(negedge clk);
        out_ready = 1'b1;
        @(negedge clk);
        out_ready = 1'b0;
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; in_valid = 1'b0; in_word = '0; out_ready = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R11 reset out_valid", {15'd0, out_valid}, 16'd0);
        chk("R11 reset in_ready", {15'd0, in_ready}, 16'd1);

        // table walk
        for (int i = 0; i < NV; i++) begin
            vec_t v = VECS[i];
            send(v.w0);
            if (v.n >= 2'd2) send(v.w1);
            if (v.n == 2'd3) send(v.w2);
            wait_bundle("table");
            chk("R1 format", {14'd0, fmt}, {14'd0, v.fmt});
            chk("R2 opword", opword, v.w0);
            chk("R2 src reg", {12'd0, src_reg}, {12'd0, v.sreg});
            chk("R3,R4,R5 src mode", {12'd0, src_mode}, {12'd0, v.smode});
            chk("R2,R6 dst reg", {12'd0, dst_reg}, {12'd0, v.dreg});
            chk("R6 dst mode", {12'd0, dst_mode}, {12'd0, v.dmode});
            chk("R4 const value", cval, v.cval);
            chk("R4 const flag", {15'd0, cvld}, {15'd0, v.cvld});
            chk("R7,R8,R9 length", {14'd0, len}, {14'd0, v.n});
            chk("R7 ext0", ext0, (v.n >= 2'd2) ? v.w1 : 16'h0000);
            chk("R7 ext1", ext1, (v.n == 2'd3) ? v.w2 : 16'h0000);
            chk("R8 illegal flag", {15'd0, illegal}, {15'd0, v.bad});
            take();
        end

        // R10: stalled bundle, input held busy
        send(16'h4504);
        wait_bundle("R10");
        @(negedge clk);
        in_valid = 1'b1;
        in_word  = 16'h4225;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            chk("R10 in_ready low", {15'd0, in_ready}, 16'd0);
            chk("R10 held valid", {15'd0, out_valid}, 16'd1);
            chk("R10 held opword", opword, 16'h4504);
            chk("R10 held length", {14'd0, len}, 16'd1);
        end
        out_ready = 1'b1;
        @(negedge clk);
        out_ready = 1'b0;
        @(negedge clk);
        in_valid = 1'b0;
        chk("R10 next taken", {15'd0, out_valid}, 16'd1);
        chk("R10 next opword", opword, 16'h4225);
        chk("R10 next const", cval, 16'h0004);
        take();
        chk("R10 taken once", {15'd0, out_valid}, 16'd0);
        chk("R10 ready again", {15'd0, in_ready}, 16'd1);

        // R11: reset in the middle of a three-word instruction
        send(16'h4697);
        send(16'h1111);
        chk("R11 no early bundle", {15'd0, out_valid}, 16'd0);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R11 after reset valid", {15'd0, out_valid}, 16'd0);
        chk("R11 after reset ready", {15'd0, in_ready}, 16'd1);
        send(16'h4504);
        wait_bundle("R11");
        chk("R11 fresh opword", opword, 16'h4504);
        chk("R11 fresh length", {14'd0, len}, 16'd1);
        chk("R11 fresh ext0", ext0, 16'h0000);
        take();

        // R8: illegal word followed at once by a two-word instruction
        send(16'h1020);
        wait_bundle("R8");
        chk("R8 resync illegal", {15'd0, illegal}, 16'd1);
        take();
        send(16'h5039);
        send(16'h0BAD);
        wait_bundle("R8");
        chk("R8 resync opword", opword, 16'h5039);
        chk("R8 resync ext0", ext0, 16'h0BAD);
        take();

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule